// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block makes the noise voice of a simple sound generator. A shift register with a linear feedback produces a pseudo-random bit stream. The register is either 15 or 7 stages long. It advances on a shift tick. That tick comes from a programmable rate divider followed by a power-of-two prescaler, both driven from the system clock. While the channel plays, the lowest stage gates a 4-bit volume: the amplitude equals the volume when that stage is 1 and zero otherwise.

A volume envelope, stepped by a 64 Hz tick, moves the volume over time. A length counter, stepped by a 256 Hz tick, can end the sound after a programmed time. A trigger pulse restarts everything from a known state. The mixer that follows reads the amplitude and the status bit. The control fields are plain inputs held by the surrounding logic.

Top module: `noise_channel`

## Requirements
- R1: A one-cycle `trig` seeds all shift-register stages with 1, loads the volume from `env_init`, sets `active`, and clears the rate and length counters. From the next cycle `amp` equals `env_init`.
- R2: On each shift tick the register moves one place toward bit 0. Bit0 XOR bit1 enters the top stage (bit 14). `amp` is the volume when bit 0 is 1 and 0 when bit 0 is 0, provided `active` is 1.
- R3: With `short_mode`=1 the feedback value is also written into bit 6, so the output bit sequence repeats every 127 shifts.
- R4: The rate divider has a base period of BASE_DIV clocks (default 8). `div_code`=0 gives a period of BASE_DIV/2 clocks, and code k in 1..7 gives BASE_DIV*k clocks.
- R5: The prescaler code s (0..13) divides the divider output by 2^(s+1). After a trigger, the n-th shift takes effect exactly n*Pd*2^(s+1) clock edges after the trigger edge, where Pd is the divider period.
- R6: `pre_code` values 14 and 15 stop the register, and `amp` holds its last level.
- R7: After reset, `active` and `amp` are 0. With `timed`=1, `active` falls on the (64-`len_init`)-th `tick_256` after the trigger. While `active` is 0, `amp` is 0.
- R8: With `timed`=0, `tick_256` pulses have no effect and the channel keeps playing.
- R9: With `env_step`=S>0, the volume moves by one on every S-th `tick_64` while active. It goes up when `env_up`=1 and down otherwise, and it saturates at 15 and 0.
- R10: With `env_step`=0 the volume stays at its initial value whatever `tick_64` does.
- R11: A trigger during playback restarts the bit sequence from the all-ones seed with the new initial volume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Restart pulse, one cycle |
| timed | input | 1 | 1: the length counter ends the sound |
| len_init | input | 6 | Length start value L; play time is 64-L ticks |
| env_init | input | 4 | Initial volume |
| env_up | input | 1 | Envelope direction, 1 = rising |
| env_step | input | 3 | 64 Hz ticks per envelope step, 0 = frozen |
| div_code | input | 3 | Rate divider code |
| pre_code | input | 4 | Prescaler exponent code, 14/15 = stopped |
| short_mode | input | 1 | 1: 7-stage sequence, 0: 15-stage |
| tick_256 | input | 1 | Length time base pulse |
| tick_64 | input | 1 | Envelope time base pulse |
| amp | output | 4 | Current amplitude |
| active | output | 1 | Channel playing status |

## Verification
The bench compares the output against a software model of the register for hundreds of shifts. It samples one edge before and on each expected shift edge, so a feedback tap in the wrong place, a missing short-mode tap, or a divider or prescaler that is off by one shows up as a miscompare. The short sequence is also checked for a repeat after exactly 127 shifts, which a register that ignores the short tap would not show. The length boundary is probed one tick before and on the expiry tick, which catches a counter that stops one step early or late. The envelope is driven past both saturation points, so a volume that wraps from 15 to 0 or from 0 to 15 is caught. The stop codes and the retrigger seed are also checked, because a design that kept clocking or left old state in the register would give a different sequence.

// File: rtl/noise_pkg.sv
package noise_pkg;
   localparam int VOL_W     = 4;
   localparam int ENVSTEP_W = 3;
   localparam int DIVCODE_W = 3;
   localparam int PRECODE_W = 4;
   localparam int LENCNT_W  = 6;

   typedef enum logic {ENV_FALL = 1'b0, ENV_RISE = 1'b1} env_dir_e;
endpackage

// File: rtl/noise_clkgen.sv
module noise_clkgen #(
   parameter int BASE_DIV = 8,
   parameter int PRE_MAX  = 13
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           restart,
   input  logic [noise_pkg::DIVCODE_W-1:0] div_code,
   input  logic [noise_pkg::PRECODE_W-1:0] pre_code,
   output logic                           shift_tick
);
   localparam int DIV_MAX = BASE_DIV * ((1 << noise_pkg::DIVCODE_W) - 1);
   localparam int DW      = $clog2(DIV_MAX + 1);
   localparam int PW      = PRE_MAX + 1;

   generate
      if (BASE_DIV < 2 || (BASE_DIV % 2) != 0) begin : g_bad_base
         $error("noise_clkgen: BASE_DIV must be even and at least 2");
      end
      if (PRE_MAX >= (1 << noise_pkg::PRECODE_W)) begin : g_bad_pre
         $error("noise_clkgen: PRE_MAX exceeds prescaler code range");
      end
   endgenerate

   logic [DW-1:0] div_cnt, div_last, code_ext;
   logic [PW-1:0] pre_cnt, pre_last;
   logic          div_tick, pre_wrap, running;

   always_comb begin
      code_ext = DW'(div_code);
      if (div_code == '0) div_last = DW'(BASE_DIV / 2 - 1);
      else                div_last = DW'(BASE_DIV) * code_ext - DW'(1);
   end

   assign running  = (pre_code <= noise_pkg::PRECODE_W'(PRE_MAX));
   assign pre_last = {PW{1'b1}} >> (PW'(PRE_MAX) - PW'(pre_code));
   assign div_tick = (div_cnt >= div_last);
   assign pre_wrap = (pre_cnt >= pre_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         pre_cnt <= '0;
      end else if (restart) begin
         div_cnt <= '0;
         pre_cnt <= '0;
      end else begin
         div_cnt <= div_tick ? '0 : div_cnt + 1'b1;
         if (div_tick && running) pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      end
   end

   assign shift_tick = running && div_tick && pre_wrap;
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
   parameter int LFSR_LEN  = 15,
   parameter int SHORT_LEN = 7,
   parameter bit HAS_SHORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                shift,
   input  logic                short_sel,
   output logic [LFSR_LEN-1:0] state
);
   generate
      if (LFSR_LEN < 3 || SHORT_LEN < 2 || SHORT_LEN >= LFSR_LEN) begin : g_bad_len
         $error("noise_lfsr: lengths out of range");
      end
   endgenerate

   logic                fb;
   logic [LFSR_LEN-1:0] nxt;

   assign fb = state[0] ^ state[1];

   generate
      if (HAS_SHORT) begin : g_dual
         always_comb begin
            nxt = {fb, state[LFSR_LEN-1:1]};
            if (short_sel) nxt[SHORT_LEN-1] = fb;
         end
      end else begin : g_single
         logic unused_sel;
         assign unused_sel = short_sel;
         always_comb nxt = {fb, state[LFSR_LEN-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= '1;
      else if (restart) state <= '1;
      else if (shift)   state <= nxt;
   end
endmodule

// File: rtl/noise_envelope.sv
module noise_envelope #(
   parameter int VW = noise_pkg::VOL_W,
   parameter int SW = noise_pkg::ENVSTEP_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          enable,
   input  logic          tick,
   input  logic [VW-1:0] init,
   input  logic          rise,
   input  logic [SW-1:0] step,
   output logic [VW-1:0] vol
);
   logic [SW-1:0] cnt, cnt_nx;
   assign cnt_nx = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol <= '0;
         cnt <= '0;
      end else if (restart) begin
         vol <= init;
         cnt <= '0;
      end else if (tick && enable && step != '0) begin
         if (cnt_nx == step) begin
            cnt <= '0;
            if (rise == noise_pkg::ENV_RISE) begin
               if (vol != '1) vol <= vol + 1'b1;
            end else begin
               if (vol != '0) vol <= vol - 1'b1;
            end
         end else begin
            cnt <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/noise_length.sv
module noise_length #(
   parameter int LW = noise_pkg::LENCNT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          timed,
   input  logic          tick,
   input  logic [LW-1:0] start,
   output logic          active
);
   logic [LW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (restart) begin
         active <= 1'b1;
         cnt    <= start;
      end else if (tick && timed && active) begin
         if (cnt == '1) active <= 1'b0;
         else           cnt    <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/noise_channel.sv
module noise_channel #(
   parameter int BASE_DIV  = 8,
   parameter int PRE_MAX   = 13,
   parameter int LFSR_LEN  = 15,
   parameter int SHORT_LEN = 7,
   parameter bit HAS_SHORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig,
   input  logic       timed,
   input  logic [5:0] len_init,
   input  logic [3:0] env_init,
   input  logic       env_up,
   input  logic [2:0] env_step,
   input  logic [2:0] div_code,
   input  logic [3:0] pre_code,
   input  logic       short_mode,
   input  logic       tick_256,
   input  logic       tick_64,
   output logic [3:0] amp,
   output logic       active
);
   logic                shift_tick;
   logic [LFSR_LEN-1:0] lfsr_q;
   logic [3:0]          vol;

   noise_clkgen #(.BASE_DIV(BASE_DIV), .PRE_MAX(PRE_MAX)) u_clk (
      .clk(clk), .rst_n(rst_n), .restart(trig),
      .div_code(div_code), .pre_code(pre_code), .shift_tick(shift_tick));

   noise_lfsr #(.LFSR_LEN(LFSR_LEN), .SHORT_LEN(SHORT_LEN), .HAS_SHORT(HAS_SHORT)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .restart(trig), .shift(shift_tick),
      .short_sel(short_mode), .state(lfsr_q));

   noise_envelope #(.VW(4), .SW(3)) u_env (
      .clk(clk), .rst_n(rst_n), .restart(trig), .enable(active), .tick(tick_64),
      .init(env_init), .rise(env_up), .step(env_step), .vol(vol));

   noise_length #(.LW(6)) u_len (
      .clk(clk), .rst_n(rst_n), .restart(trig), .timed(timed), .tick(tick_256),
      .start(len_init), .active(active));

   assign amp = (active && lfsr_q[0]) ? vol : 4'd0;
endmodule

// File: rtl/noise_channel_chk.sv
module noise_channel_chk #(
   parameter int LFSR_LEN = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic                trig,
   input logic                timed,
   input logic [3:0]          env_init,
   input logic [3:0]          pre_code,
   input logic                tick_256,
   input logic                tick_64,
   input logic [3:0]          amp,
   input logic                active,
   input logic [3:0]          vol,
   input logic [LFSR_LEN-1:0] lfsr_q
);
   a_r1_trigger_start: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (active && amp == $past(env_init)));

   a_r7_silent_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> amp == 4'd0);

   a_r7_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(tick_256 && timed));

   a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_code >= 4'd14 && !trig && !tick_64 && !tick_256) |=> $stable(amp));

   a_r2_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> ({1'b0, vol} == {1'b0, $past(vol)} ||
                 {1'b0, vol} == {1'b0, $past(vol)} + 5'd1 ||
                 {1'b0, vol} + 5'd1 == {1'b0, $past(vol)}));
endmodule

bind noise_channel noise_channel_chk #(.LFSR_LEN(LFSR_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .timed(timed), .env_init(env_init),
   .pre_code(pre_code), .tick_256(tick_256), .tick_64(tick_64), .amp(amp),
   .active(active), .vol(vol), .lfsr_q(lfsr_q));

// File: tb/tb_noise_channel.sv
`timescale 1ns/1ps
module tb_noise_channel;
   localparam int BASE = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic trig = 0, timed = 0, env_up = 0, short_mode = 0, tick_256 = 0, tick_64 = 0;
   logic [5:0] len_init = 0;
   logic [3:0] env_init = 0, pre_code = 0;
   logic [2:0] env_step = 0, div_code = 0;
   logic [3:0] amp;
   logic       active;

   int vectors = 0, errors = 0;
   logic [14:0] mq;
   logic [3:0]  seen [0:253];

   always #2.5 clk = ~clk;

   noise_channel dut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .timed(timed), .len_init(len_init),
      .env_init(env_init), .env_up(env_up), .env_step(env_step), .div_code(div_code),
      .pre_code(pre_code), .short_mode(short_mode), .tick_256(tick_256),
      .tick_64(tick_64), .amp(amp), .active(active));

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [14:0] model_step(input logic [14:0] q, input logic sh);
      logic fb;
      logic [14:0] n;
      fb = q[0] ^ q[1];
      n  = {fb, q[14:1]};
      if (sh) n[6] = fb;
      return n;
   endfunction

   function automatic int period(input int dc, input int pc);
      int pd;
      pd = (dc == 0) ? BASE / 2 : BASE * dc;
      return pd * (1 << (pc + 1));
   endfunction

   task automatic fire();
      @(negedge clk) trig = 1;
      @(negedge clk) trig = 0;
      mq = '1;
   endtask

   task automatic pulse256();
      @(negedge clk) tick_256 = 1;
      @(negedge clk) tick_256 = 0;
   endtask

   task automatic pulse64();
      @(negedge clk) tick_64 = 1;
      @(negedge clk) tick_64 = 0;
   endtask

   // Runs n shifts with period p, checking one edge before and on each shift edge.
   task automatic run_shifts(input int p, input int n, input string req, input bit keep);
      logic [3:0] e;
      for (int i = 0; i < n; i++) begin
         repeat (p - 1) @(posedge clk);
         @(negedge clk);
         e = mq[0] ? env_init : 4'd0;
         chk(amp == e, req, amp, e);
         mq = model_step(mq, short_mode);
         @(posedge clk);
         @(negedge clk);
         e = mq[0] ? env_init : 4'd0;
         chk(amp == e, req, amp, e);
         if (keep && i < 254) seen[i] = amp;
      end
   endtask

   task automatic t_reset();
      chk(active == 1'b0, "R7 reset active", active, 0);
      chk(amp == 4'd0, "R7 reset amp", amp, 0);
   endtask

   task automatic t_trigger();
      timed = 0; pre_code = 4'd15; env_step = 0; env_init = 4'd11;
      fire();
      chk(active == 1'b1, "R1 active after trig", active, 1);
      chk(amp == 4'd11, "R1 amp after trig", amp, 11);
   endtask

   task automatic t_long();
      short_mode = 0; div_code = 3'd1; pre_code = 4'd0; env_init = 4'd9;
      fire();
      run_shifts(period(1, 0), 200, "R2 long sequence", 1'b0);
   endtask

   task automatic t_short();
      int diffs;
      short_mode = 1; div_code = 3'd0; pre_code = 4'd0; env_init = 4'd5;
      fire();
      run_shifts(period(0, 0), 254, "R3 short sequence", 1'b1);
      diffs = 0;
      for (int i = 0; i < 127; i++) if (seen[i] != seen[i + 127]) diffs++;
      chk(diffs == 0, "R3 repeat after 127", diffs, 0);
      diffs = 0;
      for (int i = 1; i < 127; i++) if (seen[i] != seen[0]) diffs++;
      chk(diffs != 0, "R3 sequence not constant", diffs, 1);
      short_mode = 0;
   endtask

   task automatic t_rates();
      env_init = 4'd7;
      div_code = 3'd3; pre_code = 4'd1; fire();
      run_shifts(period(3, 1), 12, "R4 R5 code3 s1", 1'b0);
      div_code = 3'd0; pre_code = 4'd2; fire();
      run_shifts(period(0, 2), 12, "R4 R5 code0 s2", 1'b0);
      div_code = 3'd7; pre_code = 4'd0; fire();
      run_shifts(period(7, 0), 12, "R4 R5 code7 s0", 1'b0);
      div_code = 3'd2; pre_code = 4'd3; fire();
      run_shifts(period(2, 3), 6, "R5 code2 s3", 1'b0);
   endtask

   task automatic t_stop();
      logic [3:0] held;
      div_code = 3'd0; pre_code = 4'd0; env_init = 4'd13; fire();
      run_shifts(period(0, 0), 5, "R6 prelude", 1'b0);
      @(negedge clk) pre_code = 4'd14;
      held = amp;
      repeat (300) @(posedge clk);
      @(negedge clk);
      chk(amp == held, "R6 code14 holds", amp, held);
      pre_code = 4'd15;
      repeat (300) @(posedge clk);
      @(negedge clk);
      chk(amp == held, "R6 code15 holds", amp, held);
   endtask

   task automatic t_length();
      pre_code = 4'd15; env_step = 0; env_init = 4'd6; timed = 1; len_init = 6'd60;
      fire();
      for (int k = 1; k <= 3; k++) begin
         pulse256();
         chk(active == 1'b1, "R7 still playing", active, 1);
      end
      pulse256();
      chk(active == 1'b0, "R7 stops on tick 64-L", active, 0);
      chk(amp == 4'd0, "R7 amp zero when idle", amp, 0);
      len_init = 6'd63; fire();
      chk(active == 1'b1, "R7 L63 start", active, 1);
      pulse256();
      chk(active == 1'b0, "R7 L63 single tick", active, 0);
   endtask

   task automatic t_continuous();
      timed = 0; len_init = 6'd63; env_init = 4'd4; fire();
      for (int k = 0; k < 10; k++) pulse256();
      chk(active == 1'b1, "R8 continuous ignores ticks", active, 1);
      chk(amp == 4'd4, "R8 amp kept", amp, 4);
   endtask

   task automatic t_env();
      int e;
      timed = 0; pre_code = 4'd15;
      env_init = 4'd3; env_up = 1; env_step = 3'd2; fire();
      for (int k = 1; k <= 30; k++) begin
         pulse64();
         e = 3 + k / 2;
         if (e > 15) e = 15;
         chk(amp == 4'(e), "R9 rising envelope", amp, e);
      end
      env_init = 4'd2; env_up = 0; env_step = 3'd1; fire();
      for (int k = 1; k <= 4; k++) begin
         pulse64();
         e = 2 - k;
         if (e < 0) e = 0;
         chk(amp == 4'(e), "R9 falling envelope", amp, e);
      end
   endtask

   task automatic t_env_frozen();
      env_init = 4'd10; env_up = 1; env_step = 3'd0; fire();
      for (int k = 0; k < 8; k++) pulse64();
      chk(amp == 4'd10, "R10 frozen envelope", amp, 10);
   endtask

   task automatic t_retrigger();
      short_mode = 0; div_code = 3'd0; pre_code = 4'd1; env_init = 4'd8; fire();
      run_shifts(period(0, 1), 9, "R11 first run", 1'b0);
      env_init = 4'd12; fire();
      chk(amp == 4'd12, "R11 new volume", amp, 12);
      run_shifts(period(0, 1), 20, "R11 restarted sequence", 1'b0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_trigger();
      t_long();
      t_short();
      t_rates();
      t_stop();
      t_length();
      t_continuous();
      t_env();
      t_env_frozen();
      t_retrigger();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule